// File: doc/BRIEF.md
# Load Data Alignment Formatter

This block turns a raw doubleword read from memory into the value a load writes to its destination register. Each beat carries the doubleword together with the access size, the starting byte offset within the doubleword, and flags that request sign extension, byte reversal, a condition record, and mark the beat as the upper half of a split access. A single byte crossbar applies the rotation and the optional reversal in one step. Per-byte logic then chooses between current bytes, held bytes and fill bytes, and the final value is tested against zero to build a four-bit condition field.

Some accesses run past the end of a doubleword. For these the caller sends two beats with identical control fields: first the lower doubleword with the upper-half flag clear, then the next doubleword with it set. The block keeps the steered bytes of the first beat and produces nothing for that beat. On the second beat it joins the held bytes with the new ones, so one result comes out. Reversal applies to the whole joined value.

Top module: `ldfmt_top`

## Requirements
- R1: Byte lane i of a doubleword is bits 8i+7..8i. The size code in_len selects 1, 2, 4 or 8 bytes for codes 0, 1, 2, 3. When in_off plus the size is at most 8 and in_brev is 0, result byte j equals input lane in_off+j for every j below the size.
- R2: With in_brev set and no split, result byte j equals input lane in_off+size-1-j for every j below the size.
- R3: With in_sext clear, every result byte at or above the size is zero.
- R4: With in_sext set, every result byte at or above the size is filled with copies of bit 7 of result byte size-1.
- R5: A beat is the lower half of a split when in_off plus the size exceeds 8 and in_second is 0. Such a beat produces no out_valid and holds its bytes. On the next beat with in_second set and the same controls, address byte k (k below the size) comes from held lane in_off+k when in_off+k is below 8, and from current lane in_off+k-8 otherwise. A beat with in_second set that is not a split takes all bytes from the current doubleword.
- R6: For a split access with in_brev set, result byte j is address byte size-1-j of the joined value. Reversal spans both doublewords.
- R7: out_valid rises exactly one cycle after every valid beat that is not the lower half of a split. It is low in every other cycle. out_data and out_cr keep their values in cycles that produce no result.
- R8: out_cr is {negative, positive, zero, overflow-summary} in bits 3..0. With in_rec set, negative is result bit 63, zero means the result is all zeros, positive means neither of those, and bit 0 copies in_so. With in_rec clear, out_cr is 0000.
- R9: A synchronous reset clears out_valid, out_data, out_cr and the held bytes. An upper-half beat that arrives after reset, with no lower half before it, takes zeros for the held bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Beat present |
| in_data | input | 64 | Raw memory doubleword |
| in_len | input | 2 | Access size code (bytes = 1 << code) |
| in_off | input | 3 | Starting byte offset within the doubleword |
| in_sext | input | 1 | Sign-extend the result |
| in_brev | input | 1 | Byte-reverse the result |
| in_second | input | 1 | Beat is the upper doubleword of a split access |
| in_rec | input | 1 | Produce condition bits |
| in_so | input | 1 | Overflow-summary bit to copy into the condition field |
| out_valid | output | 1 | Formatted result present |
| out_data | output | 64 | Formatted result |
| out_cr | output | 4 | Condition field {neg, pos, zero, so} |

## Verification
Most internal state is combinational and reaches out_data one cycle after the beat. A wrong crossbar select or source choice therefore shows up as a misplaced or wrongly filled byte on the next out_valid. The held bytes are the only state that outlives a beat. A fault in them appears only on the upper half of a split, which can come any number of idle cycles later, so the bench inserts gaps between halves and also sends an upper half straight after reset. A wrong valid decision shows at once as an extra or missing out_valid pulse, or as out_data changing in a cycle that produces no result.

// File: rtl/ldfmt_pkg.sv
`timescale 1ns/1ps
package ldfmt_pkg;

   // Condition field, most significant first
   typedef struct packed {
      logic neg;
      logic pos;
      logic zero;
      logic so;
   } cond_t;

   // Where a result byte is taken from
   typedef enum logic [1:0] {
      SRC_CUR  = 2'd0,
      SRC_HELD = 2'd1,
      SRC_FILL = 2'd2
   } bsrc_e;

endpackage

// File: rtl/ldfmt_xbar.sv
`timescale 1ns/1ps
module ldfmt_xbar #(
   parameter  int NBYTES = 8,
   localparam int OFF_W  = $clog2(NBYTES),
   localparam int DW     = NBYTES * 8
) (
   input  logic [DW-1:0]    raw,
   input  logic [OFF_W-1:0] off,
   input  logic [OFF_W-1:0] lm1,
   input  logic             brev,
   output logic [DW-1:0]    steered
);

   // One NBYTES:1 byte mux per output lane; the select folds rotation and
   // mirroring into a single lane number (wrap-around is modulo NBYTES).
   for (genvar j = 0; j < NBYTES; j++) begin : g_lane
      localparam logic [OFF_W-1:0] JJ = OFF_W'(j);
      logic [OFF_W-1:0] sel;
      logic [7:0]       pick;

      assign sel = brev ? OFF_W'(off + lm1 - JJ) : OFF_W'(off + JJ);

      always_comb begin
         pick = 8'h00;
         for (int l = 0; l < NBYTES; l++) begin
            if (sel == OFF_W'(l)) pick = raw[l*8 +: 8];
         end
      end

      assign steered[j*8 +: 8] = pick;
   end

endmodule

// File: rtl/ldfmt_splice.sv
`timescale 1ns/1ps
module ldfmt_splice
   import ldfmt_pkg::*;
#(
   parameter  int NBYTES = 8,
   localparam int OFF_W  = $clog2(NBYTES),
   localparam int DW     = NBYTES * 8
) (
   input  logic [DW-1:0]    cur,
   input  logic [DW-1:0]    held,
   input  logic [OFF_W-1:0] off,
   input  logic [OFF_W-1:0] lm1,
   input  logic             brev,
   input  logic             use_held,
   input  logic             sext,
   output logic [DW-1:0]    shaped
);

   logic [DW-1:0] merged;
   logic          sign_bit;

   // Top bit of the most significant byte inside the access
   assign sign_bit = merged[{lm1, 3'b111}];

   for (genvar j = 0; j < NBYTES; j++) begin : g_byte
      localparam logic [OFF_W-1:0] JJ = OFF_W'(j);
      logic [OFF_W-1:0] k;       // address-order index of this result byte
      logic             in_rng;
      logic             near;    // address byte lies in the lower doubleword
      bsrc_e            src;

      assign k      = brev ? OFF_W'(lm1 - JJ) : JJ;
      assign in_rng = (JJ <= lm1);
      assign near   = (({1'b0, off} + {1'b0, k}) < (OFF_W+1)'(NBYTES));

      always_comb begin
         if (!in_rng)                src = SRC_FILL;
         else if (use_held && near)  src = SRC_HELD;
         else                        src = SRC_CUR;
      end

      assign merged[j*8 +: 8] = (src == SRC_HELD) ? held[j*8 +: 8] : cur[j*8 +: 8];
      assign shaped[j*8 +: 8] = (src == SRC_FILL) ? {8{sext & sign_bit}}
                                                  : merged[j*8 +: 8];
   end

endmodule

// File: rtl/ldfmt_cond.sv
`timescale 1ns/1ps
module ldfmt_cond
   import ldfmt_pkg::*;
#(
   parameter int DW = 64
) (
   input  logic [DW-1:0] value,
   input  logic          rec,
   input  logic          so,
   output cond_t         flags
);

   logic is_zero;
   assign is_zero = (value == '0);

   always_comb begin
      flags = '0;
      if (rec) begin
         flags.neg  = value[DW-1];
         flags.zero = is_zero;
         flags.pos  = !value[DW-1] && !is_zero;
         flags.so   = so;
      end
   end

   always_comb begin
      AST_COND_EXCL: assert ($countones({flags.neg, flags.pos, flags.zero}) <= 1); // R8
   end

endmodule

// File: rtl/ldfmt_top.sv
`timescale 1ns/1ps
module ldfmt_top
   import ldfmt_pkg::*;
#(
   parameter  int NBYTES   = 8,
   parameter  bit SPLIT_EN = 1'b1,
   localparam int OFF_W    = $clog2(NBYTES),
   localparam int LEN_W    = $clog2(OFF_W + 1),
   localparam int DW       = NBYTES * 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic [DW-1:0]    in_data,
   input  logic [LEN_W-1:0] in_len,
   input  logic [OFF_W-1:0] in_off,
   input  logic             in_sext,
   input  logic             in_brev,
   input  logic             in_second,
   input  logic             in_rec,
   input  logic             in_so,
   output logic             out_valid,
   output logic [DW-1:0]    out_data,
   output logic [3:0]       out_cr
);

   if (NBYTES < 2 || (NBYTES & (NBYTES - 1)) != 0) begin : g_bad_nbytes
      $error("ldfmt_top: NBYTES must be a power of two, at least 2");
   end

   logic [OFF_W-1:0] lm1;
   logic             split;
   logic             first_beat;
   logic             use_held;
   logic             produce;
   logic [DW-1:0]    steered;
   logic [DW-1:0]    held_q;
   logic [DW-1:0]    shaped;
   cond_t            flags;

   // Size code to "bytes minus one"; codes past the widest size saturate
   assign lm1 = (in_len >= LEN_W'(OFF_W)) ? '1 : OFF_W'((1 << in_len) - 1);
   assign split = (({1'b0, in_off} + {1'b0, lm1}) >= (OFF_W+1)'(NBYTES));

   ldfmt_xbar #(.NBYTES(NBYTES)) u_xbar (
      .raw     (in_data),
      .off     (in_off),
      .lm1     (lm1),
      .brev    (in_brev),
      .steered (steered)
   );

   if (SPLIT_EN) begin : g_split
      assign first_beat = in_valid && !in_second && split;
      assign use_held   = in_second && split;

      always_ff @(posedge clk) begin
         if (rst)             held_q <= '0;
         else if (first_beat) held_q <= steered;
      end
   end else begin : g_nosplit
      assign first_beat = 1'b0;
      assign use_held   = 1'b0;
      assign held_q     = '0;
   end

   ldfmt_splice #(.NBYTES(NBYTES)) u_splice (
      .cur      (steered),
      .held     (held_q),
      .off      (in_off),
      .lm1      (lm1),
      .brev     (in_brev),
      .use_held (use_held),
      .sext     (in_sext),
      .shaped   (shaped)
   );

   ldfmt_cond #(.DW(DW)) u_cond (
      .value (shaped),
      .rec   (in_rec),
      .so    (in_so),
      .flags (flags)
   );

   assign produce = in_valid && !first_beat;

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_data  <= '0;
         out_cr    <= '0;
      end else begin
         out_valid <= produce;
         if (produce) begin
            out_data <= shaped;
            out_cr   <= flags;
         end
      end
   end

   AST_FIRST_SILENT: assert property (@(posedge clk) disable iff (rst)
      first_beat |=> !out_valid); // R5
   AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !first_beat) |=> out_valid); // R7
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
      !(in_valid && !first_beat) |=> ($stable(out_data) && $stable(out_cr))); // R7
   AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_cr[1]) |-> (out_data == '0)); // R8
   AST_NOSEXT_TOP: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !first_beat && !in_sext && in_len < LEN_W'(OFF_W))
      |=> (out_data[DW-1 -: 8] == 8'h00)); // R3

endmodule

// File: tb/sim_ldfmt_top.sv
`timescale 1ns/1ps
module sim_ldfmt_top;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [63:0] in_data = '0;
   logic [1:0]  in_len = '0;
   logic [2:0]  in_off = '0;
   logic        in_sext = 1'b0;
   logic        in_brev = 1'b0;
   logic        in_second = 1'b0;
   logic        in_rec = 1'b0;
   logic        in_so = 1'b0;
   logic        out_valid;
   logic [63:0] out_data;
   logic [3:0]  out_cr;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   // reference state
   logic        exp_valid = 1'b0;
   logic [63:0] exp_data  = '0;
   logic [3:0]  exp_cr    = '0;
   logic [63:0] low_dw    = '0;

   always #2.5 clk = ~clk;

   ldfmt_top u0 (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
      .in_len(in_len), .in_off(in_off), .in_sext(in_sext), .in_brev(in_brev),
      .in_second(in_second), .in_rec(in_rec), .in_so(in_so),
      .out_valid(out_valid), .out_data(out_data), .out_cr(out_cr)
   );

   // Address-order model: bytes of the access in memory order, then reorder
   function automatic logic [63:0] ref_fmt(input logic [63:0] lo, input logic [63:0] cur,
                                           input int len, input int off,
                                           input bit sx, input bit br, input bit sec);
      logic [7:0]  m [8];
      logic [7:0]  r [8];
      logic [63:0] res;
      int          nb = 1 << len;
      bit          spl = (off + nb) > 8;
      bit          sgn;
      for (int k = 0; k < 8; k++) m[k] = 8'h00;
      for (int k = 0; k < nb; k++) begin
         int a = off + k;
         if (a < 8) m[k] = (sec && spl) ? lo[a*8 +: 8] : cur[a*8 +: 8];
         else       m[k] = cur[(a-8)*8 +: 8];
      end
      for (int j = 0; j < nb; j++) r[j] = br ? m[nb-1-j] : m[j];
      sgn = r[nb-1][7];
      for (int j = nb; j < 8; j++) r[j] = (sx && sgn) ? 8'hFF : 8'h00;
      for (int j = 0; j < 8; j++) res[j*8 +: 8] = r[j];
      return res;
   endfunction

   task automatic chk(input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic compare(input string tag);
      chk(tag, "out_valid", {63'd0, out_valid}, {63'd0, exp_valid});
      chk(tag, "out_data", out_data, exp_data);
      chk(tag, "out_cr", {60'd0, out_cr}, {60'd0, exp_cr});
   endtask

   // Called at a falling edge: drive a beat, advance the model, check next fall
   task automatic step(input bit v, input logic [63:0] d, input int len, input int off,
                       input bit sx, input bit br, input bit sec, input bit rec,
                       input bit so, input string tag);
      in_valid = v; in_data = d; in_len = 2'(len); in_off = 3'(off);
      in_sext = sx; in_brev = br; in_second = sec; in_rec = rec; in_so = so;
      if (v) begin
         if (!sec && (off + (1 << len)) > 8) begin
            low_dw    = d;
            exp_valid = 1'b0;
         end else begin
            exp_valid = 1'b1;
            exp_data  = ref_fmt(low_dw, d, len, off, sx, br, sec);
            exp_cr    = rec ? {exp_data[63], (!exp_data[63] && exp_data != 0),
                               (exp_data == 0), so} : 4'b0000;
         end
      end else begin
         exp_valid = 1'b0;
      end
      @(negedge clk);
      compare(tag);
   endtask

   task automatic do_reset(input int n);
      rst = 1'b1; in_valid = 1'b0;
      exp_valid = 1'b0; exp_data = '0; exp_cr = '0; low_dw = '0;
      repeat (n) @(negedge clk);
      compare("R9");
      rst = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [63:0] pat;
      pat = 64'h8877_6655_4433_2211;
      @(negedge clk);
      do_reset(3);

      // R1 normal order, no split
      step(1, pat, 3, 0, 0, 0, 0, 0, 0, "R1");
      step(1, pat, 0, 5, 0, 0, 0, 0, 0, "R1");
      step(1, pat, 1, 6, 0, 0, 0, 0, 0, "R1");
      step(1, pat, 2, 4, 0, 0, 0, 0, 0, "R1");
      // R2 reversed, no split
      step(1, pat, 2, 0, 0, 1, 0, 0, 0, "R2");
      step(1, pat, 1, 3, 0, 1, 0, 0, 0, "R2");
      step(1, pat, 3, 0, 0, 1, 0, 0, 0, "R2");
      // R3 zero fill of a negative byte
      step(1, pat, 0, 7, 0, 0, 0, 0, 0, "R3");
      step(1, pat, 1, 2, 0, 1, 0, 0, 0, "R3");
      // R4 sign fill, negative and positive
      step(1, pat, 0, 7, 1, 0, 0, 0, 0, "R4");
      step(1, pat, 1, 2, 1, 0, 0, 0, 0, "R4");
      step(1, 64'h0000_0000_8000_0000, 2, 0, 1, 0, 0, 0, 0, "R4");
      step(1, pat, 1, 6, 1, 1, 0, 0, 0, "R4");
      // R5 split accesses, with idle gaps between halves
      step(1, pat, 2, 6, 0, 0, 0, 0, 0, "R5");
      step(1, 64'hFFEE_DDCC_BBAA_9988, 2, 6, 0, 0, 1, 0, 0, "R5");
      step(1, pat, 3, 3, 1, 0, 0, 0, 0, "R5");
      step(0, '0, 0, 0, 0, 0, 0, 0, 0, "R5");
      step(1, 64'hF0E0_D0C0_B0A0_9080, 3, 3, 1, 0, 1, 0, 0, "R5");
      step(1, 64'h0102_0304_0506_0708, 1, 2, 0, 0, 1, 0, 0, "R5");
      // R6 reversed split
      step(1, pat, 3, 5, 0, 1, 0, 0, 0, "R6");
      step(1, 64'hFFEE_DDCC_BBAA_9988, 3, 5, 0, 1, 1, 0, 0, "R6");
      step(1, pat, 1, 7, 1, 1, 0, 0, 0, "R6");
      step(1, 64'h0000_0000_0000_0080, 1, 7, 1, 1, 1, 0, 0, "R6");
      // R7 hold during idle and on a lower-half beat
      step(0, 64'h1234, 0, 0, 0, 0, 0, 0, 0, "R7");
      step(0, 64'h5678, 1, 1, 1, 1, 0, 1, 1, "R7");
      step(1, pat, 2, 7, 0, 0, 0, 1, 1, "R7");
      step(1, pat, 2, 7, 0, 0, 1, 1, 1, "R7");
      // R8 condition field
      step(1, 64'h0, 3, 0, 0, 0, 0, 1, 0, "R8");
      step(1, 64'h8000_0000_0000_0000, 3, 0, 0, 0, 0, 1, 1, "R8");
      step(1, 64'h0000_0000_0000_0042, 0, 0, 0, 0, 0, 1, 0, "R8");
      step(1, 64'h8000_0000_0000_0000, 3, 0, 0, 0, 0, 0, 1, "R8");
      // R9 reset clears held bytes
      step(1, pat, 3, 4, 0, 0, 0, 0, 0, "R9");
      do_reset(1);
      step(1, 64'hA1A2_A3A4_A5A6_A7A8, 3, 4, 0, 0, 1, 0, 0, "R9");

      // mixed traffic
      for (int i = 0; i < 600; i++) begin
         int          ln  = $urandom_range(0, 3);
         int          of  = $urandom_range(0, 7);
         bit          sx  = 1'($urandom);
         bit          br  = 1'($urandom);
         bit          rc  = 1'($urandom);
         bit          so  = 1'($urandom);
         logic [63:0] d0  = {$urandom, $urandom};
         logic [63:0] d1  = {$urandom, $urandom};
         if ($urandom_range(0, 5) == 0) step(0, d1, ln, of, sx, br, 0, rc, so, "R7");
         if (of + (1 << ln) > 8) begin
            step(1, d0, ln, of, sx, br, 0, rc, so, br ? "R6" : "R5");
            if ($urandom_range(0, 3) == 0) step(0, d0, 0, 0, 0, 0, 0, 0, 0, "R7");
            step(1, d1, ln, of, sx, br, 1, rc, so, br ? "R6" : "R5");
         end else begin
            step(1, d0, ln, of, sx, br, 1'($urandom), rc, so, br ? "R2" : "R1");
         end
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule